// File: doc/BRIEF.md
# Multi-Threshold Real-Time Counter with Cyclic Timer

This block is the timekeeping unit of a low-power receiver. It counts a slow tick enable (nominally 32768 Hz) in a free-running 40-bit counter. Four compare channels watch that counter: two narrow channels compare only the low 16 bits, and two wide channels compare the full 40 bits. A separate cyclic timer divides the tick by an 8-bit prescaler and counts up to a programmable 16-bit top value. At a 32768 Hz tick the longest cyclic period is about 8.5 minutes.

Software configures the unit through byte-wide writes. Each channel and the cyclic timer has its own enable bit. Each channel records its events in a sticky status bit, which software clears by writing 1 to that bit. Any channel event also drives a one-cycle RTC alarm pulse, and each wrap of the cyclic timer drives a one-cycle cyclic alarm pulse. The 40-bit counter is read a byte at a time. Reading the top byte freezes the remaining 32 bits, so the bytes read afterwards all belong to the same count.

Top module: `rtc_timer_unit`

## Requirements
- R1: After reset the counter is zero. It increases by exactly one at each clock edge where `tick_i` is high, and it holds its value at every other edge.
- R2: A read issued with `rd_en_i` appears on `rd_data_o` in the following cycle. Address 0x20 returns counter bits 39:32 and freezes bits 31:0. Addresses 0x21, 0x22, 0x23 and 0x24 return bits 31:24, 23:16, 15:8 and 7:0 of that frozen copy.
- R3: Narrow channel i (i = 0, 1) takes its low threshold byte at address 0x08+2i and its high byte at 0x09+2i. Suppose channel i is enabled and a tick moves the counter so that its low 16 bits equal the threshold. At that edge, status bit i sets and `rtc_alarm_o` goes high for exactly one cycle.
- R4: Wide channel i (i = 0, 1) takes threshold byte b (bits 8b+7:8b, b = 0..4) at address 0x10+8i+b. It fires only when all 40 counter bits equal the threshold, and it sets status bit 2+i. A match of the low 16 bits alone does not fire it.
- R5: The enable register is at address 0x00. Bits 0 and 1 enable the narrow channels, bits 2 and 3 enable the wide channels, and bit 4 enables the cyclic timer. A disabled channel never sets status or pulses the alarm. A threshold equal to the counter fires only when a tick moves the counter onto it, never while the counter stands still.
- R6: Status bits 3:0 are read at address 0x28, and bits 7:4 read as zero. Status bits stay set until a write to address 0x01 clears each bit that has a 1 in the written data. If an event and a clear of the same bit fall on one edge, the bit ends up set.
- R7: The prescaler P is at address 0x02, and the value 0 acts as 1. The cyclic top value T has its low byte at 0x03 and its high byte at 0x04. While enabled, the cyclic count advances once every P ticks and returns to zero from T. `cyc_alarm_o` is high for one cycle at each return to zero, so the first pulse comes P*(T+1) ticks after enable.
- R8: While the cyclic timer is disabled, its prescaler count and cyclic count are held at zero. A later enable therefore starts a full period, and no cyclic alarm occurs while it is disabled.
- R9: After reset all thresholds, enables, prescaler, top and status are zero, and both alarm outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow tick enable, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Write address |
| wr_data_i | input | 8 | Write data byte |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 6 | Read address |
| rd_data_o | output | 8 | Read data, valid the cycle after the strobe |
| status_o | output | 4 | Sticky per-channel event bits |
| rtc_alarm_o | output | 1 | One-cycle pulse on any enabled channel match |
| cyc_alarm_o | output | 1 | One-cycle pulse on cyclic wrap |

## Verification
A channel can set its status bit at the same edge at which software writes the clear register. The bench provokes this collision with a single cycle that drives both a tick and a clear. That tick moves the counter onto a narrow threshold, and the same write clears both that channel's bit and another bit that is already set. A status read then has to show the colliding bit still set and the other bit cleared. Cyclic wraps are timed against the bench's own tick count, including one restart after the timer was disabled partway through a period.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W     = 6;
  localparam int A_SEL      = 'h00;
  localparam int A_CLR      = 'h01;
  localparam int A_PRESC    = 'h02;
  localparam int A_TOP_LO   = 'h03;
  localparam int A_TOP_HI   = 'h04;
  localparam int A_SH_BASE  = 'h08;
  localparam int A_LG_BASE  = 'h10;
  localparam int LG_STRIDE  = 8;
  localparam int A_CNT_BASE = 'h20;
  localparam int A_STATUS   = 'h28;
endpackage

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int CNT_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/rtc_cmp_channel.sv
module rtc_cmp_channel #(
  parameter int W      = 16,
  parameter int AW     = 6,
  parameter int BASE   = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          step_i,
  input  logic [W-1:0]  cmp_val_i,
  output logic          hit_o
);
  localparam int NB = W / 8;

  logic [W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= '0;
    end else if (wr_en_i) begin
      for (int b = 0; b < NB; b++) begin
        if (wr_addr_i == AW'(BASE + b)) thr_q[8*b +: 8] <= wr_data_i;
      end
    end
  end

  // compare against the value the counter is about to take
  assign hit_o = step_i && (cmp_val_i == thr_q);
endmodule

// File: rtl/rtc_cyclic.sv
module rtc_cyclic #(
  parameter int PRE_W = 8,
  parameter int TOP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic [TOP_W-1:0] top_i,
  output logic [TOP_W-1:0] cyc_o,
  output logic             wrap_o
);
  logic [PRE_W-1:0] pcnt_q;
  logic [TOP_W-1:0] cyc_q;
  logic             wrap_q;
  logic [PRE_W-1:0] pre_last;
  logic             pre_done;

  assign pre_last = (presc_i == '0) ? '0 : presc_i - 1'b1;
  assign pre_done = (pcnt_q >= pre_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      cyc_q  <= '0;
      wrap_q <= 1'b0;
    end else if (!en_i) begin
      pcnt_q <= '0;
      cyc_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (tick_i) begin
        if (pre_done) begin
          pcnt_q <= '0;
          if (cyc_q >= top_i) begin
            cyc_q  <= '0;
            wrap_q <= 1'b1;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end
  end

  assign cyc_o  = cyc_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int CNT_W = 40,
  parameter int PRE_W = 8,
  parameter int TOP_W = 16,
  parameter int SEL_W = 5,
  parameter int N_CH  = 4,
  parameter int AW    = ADDR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [N_CH-1:0]  status_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [PRE_W-1:0] presc_o,
  output logic [TOP_W-1:0] top_o,
  output logic [7:0]       rd_data_o
);
  localparam int NCB    = CNT_W / 8;
  localparam int SNAP_W = CNT_W - 8;
  localparam int TOP_NB = TOP_W / 8;

  logic [SEL_W-1:0]  sel_q;
  logic [PRE_W-1:0]  presc_q;
  logic [TOP_W-1:0]  top_q;
  logic [SNAP_W-1:0] snap_q;
  logic [7:0]        rd_q;
  logic [7:0]        rd_byte;
  logic              take_snap;
  int unsigned       off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      presc_q <= '0;
      top_q   <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == AW'(A_SEL))   sel_q   <= wr_data_i[SEL_W-1:0];
      if (wr_addr_i == AW'(A_PRESC)) presc_q <= wr_data_i[PRE_W-1:0];
      for (int b = 0; b < TOP_NB; b++) begin
        if (wr_addr_i == AW'(A_TOP_LO + b)) top_q[8*b +: 8] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_byte   = '0;
    take_snap = 1'b0;
    off       = 32'(rd_addr_i) - 32'(A_CNT_BASE);
    if (off == 0) begin
      rd_byte   = cnt_i[CNT_W-1 -: 8];
      take_snap = 1'b1;
    end else if (off < NCB) begin
      for (int k = 0; k < NCB - 1; k++) begin
        if (off == 32'(NCB - 1 - k)) rd_byte = snap_q[8*k +: 8];
      end
    end else if (rd_addr_i == AW'(A_STATUS)) begin
      rd_byte[N_CH-1:0] = status_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      snap_q <= '0;
    end else if (rd_en_i) begin
      rd_q <= rd_byte;
      if (take_snap) snap_q <= cnt_i[SNAP_W-1:0];
    end
  end

  assign sel_o     = sel_q;
  assign presc_o   = presc_q;
  assign top_o     = top_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/rtc_timer_unit.sv
module rtc_timer_unit
  import rtc_pkg::*;
#(
  parameter int CNT_W = 40,
  parameter int SH_W  = 16,
  parameter int N_SH  = 2,
  parameter int N_LG  = 2,
  parameter int PRE_W = 8,
  parameter int TOP_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [7:0]           wr_data_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [7:0]           rd_data_o,
  output logic [N_SH+N_LG-1:0] status_o,
  output logic                 rtc_alarm_o,
  output logic                 cyc_alarm_o
);
  localparam int N_CH  = N_SH + N_LG;
  localparam int SEL_W = N_CH + 1;
  localparam int SH_NB = SH_W / 8;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [SEL_W-1:0] sel;
  logic [PRE_W-1:0] presc;
  logic [TOP_W-1:0] top;
  logic [TOP_W-1:0] cyc_cnt;
  logic             cyc_en;
  logic [N_CH-1:0]  hit;
  logic [N_CH-1:0]  clr_mask;
  logic [N_CH-1:0]  status_q;
  logic             rtc_alarm_q;

  rtc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .cnt_o     (cnt_q),
    .cnt_nxt_o (cnt_nxt)
  );

  rtc_regs #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .TOP_W(TOP_W),
    .SEL_W(SEL_W), .N_CH(N_CH), .AW(ADDR_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_en_i, .rd_addr_i,
    .cnt_i     (cnt_q),
    .status_i  (status_q),
    .sel_o     (sel),
    .presc_o   (presc),
    .top_o     (top),
    .rd_data_o (rd_data_o)
  );

  for (genvar i = 0; i < N_SH; i++) begin : g_short
    rtc_cmp_channel #(.W(SH_W), .AW(ADDR_W), .BASE(A_SH_BASE + i*SH_NB)) u_ch (
      .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
      .step_i    (tick_i && sel[i]),
      .cmp_val_i (cnt_nxt[SH_W-1:0]),
      .hit_o     (hit[i])
    );
  end

  for (genvar i = 0; i < N_LG; i++) begin : g_long
    rtc_cmp_channel #(.W(CNT_W), .AW(ADDR_W), .BASE(A_LG_BASE + i*LG_STRIDE)) u_ch (
      .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
      .step_i    (tick_i && sel[N_SH+i]),
      .cmp_val_i (cnt_nxt),
      .hit_o     (hit[N_SH+i])
    );
  end

  assign cyc_en = sel[N_CH];

  rtc_cyclic #(.PRE_W(PRE_W), .TOP_W(TOP_W)) u_cyc (
    .clk_i, .rst_ni, .tick_i,
    .en_i    (cyc_en),
    .presc_i (presc),
    .top_i   (top),
    .cyc_o   (cyc_cnt),
    .wrap_o  (cyc_alarm_o)
  );

  assign clr_mask = (wr_en_i && wr_addr_i == ADDR_W'(A_CLR)) ? wr_data_i[N_CH-1:0] : '0;

  // a new event outranks a clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q    <= '0;
      rtc_alarm_q <= 1'b0;
    end else begin
      status_q    <= (status_q & ~clr_mask) | hit;
      rtc_alarm_q <= |hit;
    end
  end

  assign status_o    = status_q;
  assign rtc_alarm_o = rtc_alarm_q;
endmodule

// File: rtl/rtc_timer_unit_chk.sv
module rtc_timer_unit_chk
  import rtc_pkg::*;
#(
  parameter int CNT_W = 40,
  parameter int N_CH  = 4,
  parameter int TOP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [TOP_W-1:0] cyc_i,
  input logic             cyc_en_i,
  input logic [N_CH-1:0]  status_i,
  input logic             rtc_alarm_i,
  input logic             cyc_alarm_i
);
  AST_CNT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_i == $past(cnt_i) + CNT_W'(1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i)); // R1
  AST_ALARM_HAS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtc_alarm_i |-> status_i != '0); // R3
  AST_ALARM_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !rtc_alarm_i && !cyc_alarm_i); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == ADDR_W'(A_CLR)) |=>
      ((status_i & $past(status_i)) == $past(status_i))); // R6
  AST_WRAP_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_alarm_i |-> cyc_i == '0); // R7
  AST_CYC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_en_i |=> cyc_i == '0 && !cyc_alarm_i); // R8
endmodule

bind rtc_timer_unit rtc_timer_unit_chk #(.CNT_W(CNT_W), .N_CH(N_CH), .TOP_W(TOP_W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i,
  .cnt_i       (cnt_q),
  .cyc_i       (cyc_cnt),
  .cyc_en_i    (cyc_en),
  .status_i    (status_o),
  .rtc_alarm_i (rtc_alarm_o),
  .cyc_alarm_i (cyc_alarm_o)
);

// File: tb/sim_rtc_timer_unit.sv
module sim_rtc_timer_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [5:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] status;
  logic       rtc_alarm;
  logic       cyc_alarm;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  longint exp_cnt = 0;
  longint tcount = 0;
  int rtc_n = 0;
  int cyc_n = 0;
  longint cyc_last = 0;
  logic t_s;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_timer_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .status_o(status), .rtc_alarm_o(rtc_alarm), .cyc_alarm_o(cyc_alarm)
  );

  task automatic check(longint act, longint exp, string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: read results one cycle after the strobe
  always @(posedge clk) begin
    if (rd_en) begin
      #2;
      if (exp_q.size() > 0) check(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  // tick and alarm monitor
  always @(posedge clk) begin
    t_s = tick;
    #1;
    if (t_s) tcount++;
    if (rtc_alarm) rtc_n++;
    if (cyc_alarm) begin cyc_n++; cyc_last = tcount; end
  end

  task automatic wr(int addr, int data);
    @(negedge clk); wr_en = 1; wr_addr = 6'(addr); wr_data = 8'(data);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int addr, logic [7:0] exp, string tag);
    @(negedge clk); rd_en = 1; rd_addr = 6'(addr);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
    exp_cnt += n;
  endtask

  task automatic tick_with_write(int addr, int data);
    @(negedge clk); tick = 1; wr_en = 1; wr_addr = 6'(addr); wr_data = 8'(data);
    @(negedge clk); tick = 0; wr_en = 0;
    exp_cnt += 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint tc0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(rtc_alarm, 0, "R9 rtc alarm after reset");
    check(cyc_alarm, 0, "R9 cyc alarm after reset");
    rd('h28, 8'h00, "R9 status after reset");
    rd('h20, 8'h00, "R9 counter msb after reset");
    rd('h24, 8'h00, "R9 counter lsb after reset");

    // thresholds
    wr('h08, 'h30); wr('h09, 'h00);          // narrow 0 = 0x0030
    wr('h0A, 'h20);                          // narrow 1 = 0x0020, disabled
    wr('h10, 'h30); wr('h14, 'h01);          // wide 0 = 0x01_0000_0030
    wr('h18, 'h10); wr('h19, 'h01);          // wide 1 = 0x110
    wr('h00, 'h0D);

    ticks(48);
    rd('h28, 8'h01, "R3 R4 R5 narrow0 fires, wide0 and narrow1 do not");
    check(rtc_n, 1, "R3 one alarm pulse");
    ticks(224);
    rd('h28, 8'h09, "R4 wide1 fires on full match");
    check(rtc_n, 2, "R4 alarm pulse count");

    // R2 coherent counter read
    rd('h20, 8'(exp_cnt >> 32), "R2 msb read");
    ticks(5);
    rd('h24, 8'h10, "R2 frozen byte0");
    rd('h23, 8'h01, "R2 frozen byte1");
    rd('h22, 8'h00, "R2 frozen byte2");
    rd('h20, 8'h00, "R2 msb re-read");
    rd('h24, 8'(exp_cnt), "R2 byte0 after refresh, R1 count");
    rd('h23, 8'(exp_cnt >> 8), "R1 count byte1");

    // R6 clear
    wr('h01, 'h01);
    rd('h28, 8'h08, "R6 clear bit0");
    wr('h01, 'h00);
    rd('h28, 8'h08, "R6 zero clear no effect");

    // R5 threshold equal to stationary counter
    wr('h0A, 8'(exp_cnt)); wr('h0B, 8'(exp_cnt >> 8));
    wr('h00, 'h0F);
    repeat (6) @(negedge clk);
    rd('h28, 8'h08, "R5 no fire without tick");
    check(rtc_n, 2, "R5 no alarm without tick");

    // R6 event and clear on the same edge
    wr('h0A, 8'(exp_cnt + 1));
    tick_with_write('h01, 'h0A);
    rd('h28, 8'h02, "R6 set wins over clear, other bit cleared");
    check(status, 4'h2, "R6 status port");
    check(rtc_n, 3, "R3 alarm on collision tick");

    // R7 cyclic
    wr('h02, 3); wr('h03, 2); wr('h04, 0);
    wr('h00, 'h1F);
    tc0 = tcount;
    ticks(27);
    @(negedge clk);
    check(cyc_n, 3, "R7 three wraps in 27 ticks");
    check(cyc_last, tc0 + 27, "R7 wrap timing");
    ticks(4);
    wr('h00, 'h0F);
    ticks(20);
    @(negedge clk);
    check(cyc_n, 3, "R8 no cyclic alarm while disabled");
    wr('h02, 0); wr('h03, 4);
    wr('h00, 'h1F);
    tc0 = tcount;
    ticks(5);
    @(negedge clk);
    check(cyc_n, 4, "R7 prescaler zero acts as one");
    check(cyc_last, tc0 + 5, "R8 restart from zero");
    check(rtc_n, 3, "R5 no stray channel alarm");

    repeat (4) @(negedge clk);
    check(exp_q.size(), 0, "scoreboard drained");
    finish_run();
  end
endmodule